// File: doc/BRIEF.md
# Latched Two-Bank Interrupt Controller

This block collects 64 interrupt request lines into two 32-bit banks and presents them to a processor as two outputs. One output is a normal interrupt request and the other is a fast one. Each line is either level sensed or edge sensed. Edge-sensed lines are caught in per-line latches that stay set until software clears them by writing a one. Every line also has an enable bit, a software trigger and a routing bit. The routing bit sends the line to either output.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. Each logical register holds one word per bank. The low-bank word (lines 0 to 31) sits at the register's base offset and the high-bank word (lines 32 to 63) sits four bytes above it. Successive registers are eight bytes apart. Enables and software triggers are changed through write-one-to-set and write-one-to-clear addresses, so a single line can be changed without a read-modify-write. All status words and both outputs are registered.

Top module: `vecint_ctrl`

## Requirements
- R1: After reset, all lines are disabled and all software triggers are off. All lines route to the normal output and all edge latches are clear. Every line is level sensed (sense word reads all ones), the event word is all ones (rising), the dual word is zero, and both outputs are low.
- R2: The register index is address bits [7:3] and the bank is address bit 2. Bank 0 holds lines 0-31 and bank 1 holds lines 32-63. Indices: 0 normal status, 1 fast status, 2 raw status, 3 route select, 4 enable set, 5 enable clear, 6 trigger set, 7 trigger clear, 8 sense, 9 dual edge, 10 event polarity, 11 edge clear, 12 edge status. A write to one bank leaves the other bank unchanged.
- R3: Writing 1 to a bit at the enable-set index enables that line. Writing 1 to the same bit at the enable-clear index disables it. Bits written 0 leave the line unchanged. Reading the enable-set index returns the enable mask.
- R4: The trigger-set and trigger-clear indices set and clear a per-line software request in the same way. Reading trigger-set returns the request mask. A software request drives raw status like a real request.
- R5: A route-select bit of 0 sends the line to the normal output (irq_o). A route-select bit of 1 sends it to the fast output (fiq_o).
- R6: With its sense bit at 1, a line is level sensed: its raw status follows its input and is not latched.
- R7: With its sense bit at 0 and its dual bit at 0, a line is edge sensed. Event bit 1 means a rising input edge sets the line's latch; event bit 0 means a falling edge does. The other edge has no effect.
- R8: With its sense bit at 0 and its dual bit at 1, both rising and falling edges set the latch.
- R9: An edge latch stays set until 1 is written to its bit at the edge-clear index. Edge clear has no effect on a level-sensed line. Edge status reads the latches, which are always 0 for level-sensed lines.
- R10: Normal status = raw AND enable AND NOT select, and fast status = raw AND enable AND select. irq_o is the OR of all normal status bits and fiq_o is the OR of all fast status bits.
- R11: A change on an enabled level-sensed input appears on irq_o or fiq_o at the next rising clock edge.
- R12: A disabled line never drives an output, but its raw status still shows its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe |
| reg_ren | input | 1 | Read strobe; data is returned on reg_rdata after the next edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data (0 for unmapped addresses and clear-only indices) |
| src_i | input | 64 | Interrupt request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle, the assertions check four things:
- No line shows in both the normal and the fast status.
- Each output equals the OR of its own status word.
- No level-sensed line holds a latch bit.
- Enable-set and enable-clear writes change the mask on the following edge.

Only the directed scenarios can show the edge-polarity choice, dual-edge capture, and latch persistence until an explicit clear. The same holds for the one-edge latency from input to output, the bank interleave of the address map, and software triggering through both banks.

// File: rtl/vecint_pkg.sv
package vecint_pkg;
  localparam int NREG      = 13;
  localparam int REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_IRQ_ST   = 4'd0,
    RI_FIQ_ST   = 4'd1,
    RI_RAW_ST   = 4'd2,
    RI_SELECT   = 4'd3,
    RI_EN_SET   = 4'd4,
    RI_EN_CLR   = 4'd5,
    RI_TRG_SET  = 4'd6,
    RI_TRG_CLR  = 4'd7,
    RI_SENSE    = 4'd8,
    RI_DUAL     = 4'd9,
    RI_EVENT    = 4'd10,
    RI_EDGE_CLR = 4'd11,
    RI_EDGE_ST  = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/vecint_decode.sv
module vecint_decode
  import vecint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int BANK_AW  = $clog2(NUM_BANKS),
  localparam int SLOT_W   = ADDR_W - 2 - BANK_AW
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              wen_i,
  output logic [BANK_AW-1:0]                bank_o,
  output reg_idx_e                          idx_o,
  output logic                              hit_o,
  output logic [NUM_BANKS-1:0][NREG-1:0]    wstb_o
);
  logic [SLOT_W-1:0] slot;

  assign slot   = addr_i[ADDR_W-1:2+BANK_AW];
  assign bank_o = addr_i[2 +: BANK_AW];
  assign idx_o  = reg_idx_e'(slot[REG_IDX_W-1:0]);
  assign hit_o  = (addr_i[1:0] == 2'b00) && (slot < SLOT_W'(NREG));

  always_comb begin
    wstb_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int r = 0; r < NREG; r++) begin
        wstb_o[b][r] = wen_i && hit_o && (bank_o == BANK_AW'(b))
                       && (slot[REG_IDX_W-1:0] == REG_IDX_W'(r));
      end
    end
  end
endmodule

// File: rtl/vecint_bank.sv
module vecint_bank
  import vecint_pkg::*;
#(
  parameter int           W         = 32,
  parameter logic [W-1:0] SENSE_RST = '1,
  parameter logic [W-1:0] EVENT_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    src_i,
  input  logic [NREG-1:0] wstb_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    irq_st_o,
  output logic [W-1:0]    fiq_st_o,
  output logic [W-1:0]    raw_st_o,
  output logic [W-1:0]    sel_o,
  output logic [W-1:0]    en_o,
  output logic [W-1:0]    soft_o,
  output logic [W-1:0]    sense_o,
  output logic [W-1:0]    dual_o,
  output logic [W-1:0]    evt_o,
  output logic [W-1:0]    latch_o,
  output logic            irq_req_o,
  output logic            fiq_req_o
);
  logic [W-1:0] en_q, soft_q, sel_q, sense_q, dual_q, evt_q, latch_q, src_d;
  logic [W-1:0] en_n, soft_n, sel_n, sense_n, dual_n, evt_n, latch_n;
  logic [W-1:0] rise, fall, hit, clr, raw_c, irq_c, fiq_c;
  logic [W-1:0] irq_st_q, fiq_st_q, raw_st_q;

  // next state of the software-visible controls
  always_comb begin
    en_n = en_q;
    if (wstb_i[RI_EN_SET]) en_n = en_n | wdata_i;
    if (wstb_i[RI_EN_CLR]) en_n = en_n & ~wdata_i;
    soft_n = soft_q;
    if (wstb_i[RI_TRG_SET]) soft_n = soft_n | wdata_i;
    if (wstb_i[RI_TRG_CLR]) soft_n = soft_n & ~wdata_i;
    sel_n   = wstb_i[RI_SELECT] ? wdata_i : sel_q;
    sense_n = wstb_i[RI_SENSE]  ? wdata_i : sense_q;
    dual_n  = wstb_i[RI_DUAL]   ? wdata_i : dual_q;
    evt_n   = wstb_i[RI_EVENT]  ? wdata_i : evt_q;
  end

  // edge capture: a new edge wins over a simultaneous clear
  assign rise    = src_i & ~src_d;
  assign fall    = ~src_i & src_d;
  assign hit     = (dual_q & (rise | fall)) | (~dual_q & evt_q & rise)
                 | (~dual_q & ~evt_q & fall);
  assign clr     = wstb_i[RI_EDGE_CLR] ? wdata_i : '0;
  assign latch_n = ((latch_q & ~clr) | (hit & ~sense_q)) & ~sense_n;

  assign raw_c = soft_q | (sense_q & src_i) | (~sense_q & latch_n);
  assign irq_c = raw_c & en_q & ~sel_q;
  assign fiq_c = raw_c & en_q & sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      soft_q   <= '0;
      sel_q    <= '0;
      sense_q  <= SENSE_RST;
      dual_q   <= '0;
      evt_q    <= EVENT_RST;
      latch_q  <= '0;
      src_d    <= '0;
      irq_st_q <= '0;
      fiq_st_q <= '0;
      raw_st_q <= '0;
    end else begin
      en_q     <= en_n;
      soft_q   <= soft_n;
      sel_q    <= sel_n;
      sense_q  <= sense_n;
      dual_q   <= dual_n;
      evt_q    <= evt_n;
      latch_q  <= latch_n;
      src_d    <= src_i;
      irq_st_q <= irq_c;
      fiq_st_q <= fiq_c;
      raw_st_q <= raw_c;
    end
  end

  assign irq_st_o  = irq_st_q;
  assign fiq_st_o  = fiq_st_q;
  assign raw_st_o  = raw_st_q;
  assign sel_o     = sel_q;
  assign en_o      = en_q;
  assign soft_o    = soft_q;
  assign sense_o   = sense_q;
  assign dual_o    = dual_q;
  assign evt_o     = evt_q;
  assign latch_o   = latch_q;
  assign irq_req_o = |irq_c;
  assign fiq_req_o = |fiq_c;
endmodule

// File: rtl/vecint_ctrl.sv
module vecint_ctrl
  import vecint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int W         = 32,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*W-1:0] SENSE_RST = '1,
  parameter logic [NUM_BANKS*W-1:0] EVENT_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wen,
  input  logic                   reg_ren,
  input  logic [W-1:0]           reg_wdata,
  output logic [W-1:0]           reg_rdata,
  input  logic [NUM_BANKS*W-1:0] src_i,
  output logic                   irq_o,
  output logic                   fiq_o
);
  localparam int NSRC    = NUM_BANKS * W;
  localparam int BANK_AW = $clog2(NUM_BANKS);

  logic [BANK_AW-1:0]              rd_bank;
  reg_idx_e                        rd_idx;
  logic                            rd_hit;
  logic [NUM_BANKS-1:0][NREG-1:0]  wstb;

  logic [W-1:0] b_irq [NUM_BANKS];
  logic [W-1:0] b_fiq [NUM_BANKS];
  logic [W-1:0] b_raw [NUM_BANKS];
  logic [W-1:0] b_sel [NUM_BANKS];
  logic [W-1:0] b_en  [NUM_BANKS];
  logic [W-1:0] b_sft [NUM_BANKS];
  logic [W-1:0] b_sns [NUM_BANKS];
  logic [W-1:0] b_dul [NUM_BANKS];
  logic [W-1:0] b_evt [NUM_BANKS];
  logic [W-1:0] b_lat [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_req, fiq_req;

  logic [NSRC-1:0] irq_stat_all, fiq_stat_all, en_all, latch_all, sense_all;
  logic [W-1:0]    rd_word;

  vecint_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (reg_addr),
    .wen_i  (reg_wen),
    .bank_o (rd_bank),
    .idx_o  (rd_idx),
    .hit_o  (rd_hit),
    .wstb_o (wstb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vecint_bank #(
      .W         (W),
      .SENSE_RST (SENSE_RST[b*W +: W]),
      .EVENT_RST (EVENT_RST[b*W +: W])
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .src_i     (src_i[b*W +: W]),
      .wstb_i    (wstb[b]),
      .wdata_i   (reg_wdata),
      .irq_st_o  (b_irq[b]),
      .fiq_st_o  (b_fiq[b]),
      .raw_st_o  (b_raw[b]),
      .sel_o     (b_sel[b]),
      .en_o      (b_en[b]),
      .soft_o    (b_sft[b]),
      .sense_o   (b_sns[b]),
      .dual_o    (b_dul[b]),
      .evt_o     (b_evt[b]),
      .latch_o   (b_lat[b]),
      .irq_req_o (irq_req[b]),
      .fiq_req_o (fiq_req[b])
    );
    assign irq_stat_all[b*W +: W] = b_irq[b];
    assign fiq_stat_all[b*W +: W] = b_fiq[b];
    assign en_all[b*W +: W]       = b_en[b];
    assign latch_all[b*W +: W]    = b_lat[b];
    assign sense_all[b*W +: W]    = b_sns[b];
  end

  always_comb begin
    rd_word = '0;
    case (rd_idx)
      RI_IRQ_ST:  rd_word = b_irq[rd_bank];
      RI_FIQ_ST:  rd_word = b_fiq[rd_bank];
      RI_RAW_ST:  rd_word = b_raw[rd_bank];
      RI_SELECT:  rd_word = b_sel[rd_bank];
      RI_EN_SET:  rd_word = b_en[rd_bank];
      RI_TRG_SET: rd_word = b_sft[rd_bank];
      RI_SENSE:   rd_word = b_sns[rd_bank];
      RI_DUAL:    rd_word = b_dul[rd_bank];
      RI_EVENT:   rd_word = b_evt[rd_bank];
      RI_EDGE_ST: rd_word = b_lat[rd_bank];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (reg_ren) reg_rdata <= rd_hit ? rd_word : '0;
      irq_o <= |irq_req;
      fiq_o <= |fiq_req;
    end
  end
endmodule

// File: rtl/vecint_chk.sv
module vecint_chk
  import vecint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int W         = 32,
  parameter int ADDR_W    = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   reg_wen,
  input logic [W-1:0]           reg_wdata,
  input logic                   irq_o,
  input logic                   fiq_o,
  input logic [NUM_BANKS*W-1:0] irq_stat_all,
  input logic [NUM_BANKS*W-1:0] fiq_stat_all,
  input logic [NUM_BANKS*W-1:0] en_all,
  input logic [NUM_BANKS*W-1:0] latch_all,
  input logic [NUM_BANKS*W-1:0] sense_all
);
  localparam logic [ADDR_W-1:0] A_ENSET_LO = ADDR_W'(int'(RI_EN_SET) * 4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] A_ENCLR_LO = ADDR_W'(int'(RI_EN_CLR) * 4 * NUM_BANKS);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_all == '0 && !irq_o && !fiq_o));

  p_enset_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == A_ENSET_LO) |=>
      ((en_all[W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

  p_enclr_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == A_ENCLR_LO) |=>
      ((en_all[W-1:0] & $past(reg_wdata)) == '0));

  p_route_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_stat_all & fiq_stat_all) == '0);

  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|irq_stat_all));

  p_fiq_or_r10: assert property (@(posedge clk) disable iff (rst)
    fiq_o == (|fiq_stat_all));

  p_lvl_nolatch_r9: assert property (@(posedge clk) disable iff (rst)
    (latch_all & sense_all) == '0);
endmodule

bind vecint_ctrl vecint_chk #(.NUM_BANKS(NUM_BANKS), .W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_addr     (reg_addr),
  .reg_wen      (reg_wen),
  .reg_wdata    (reg_wdata),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .irq_stat_all (irq_stat_all),
  .fiq_stat_all (fiq_stat_all),
  .en_all       (en_all),
  .latch_all    (latch_all),
  .sense_all    (sense_all)
);

// File: tb/vecint_ctrl_tb.sv
`timescale 1ns/1ps
module vecint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] src = '0;
  logic        irq_o, fiq_o;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  vecint_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_i(src), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // register indices, see R2
  localparam int I_IRQ = 0, I_FIQ = 1, I_RAW = 2, I_SEL = 3, I_ENS = 4, I_ENC = 5;
  localparam int I_TGS = 6, I_TGC = 7, I_SNS = 8, I_DUL = 9, I_EVT = 10, I_ECL = 11, I_EST = 12;

  function automatic logic [7:0] ra(int idx, int bank);
    return 8'(idx * 8 + bank * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, int bank, logic [31:0] d);
    @(negedge clk);
    reg_addr = ra(idx, bank); reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic chk_reg(string tag, int idx, int bank, logic [31:0] exp);
    @(negedge clk);
    reg_addr = ra(idx, bank); reg_ren = 1'b1;
    @(negedge clk);
    reg_ren = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq_o low", 32'(irq_o), 0);
    chk("R1 fiq_o low", 32'(fiq_o), 0);
    chk_reg("R1 enable lo", I_ENS, 0, 0);
    chk_reg("R1 enable hi", I_ENS, 1, 0);
    chk_reg("R1 select lo", I_SEL, 0, 0);
    chk_reg("R1 trigger hi", I_TGS, 1, 0);
    chk_reg("R1 edge status lo", I_EST, 0, 0);
    chk_reg("R1 sense lo", I_SNS, 0, 32'hFFFF_FFFF);
    chk_reg("R1 event hi", I_EVT, 1, 32'hFFFF_FFFF);
    chk_reg("R1 dual lo", I_DUL, 0, 0);
  endtask

  task automatic t_enable;
    wr(I_ENS, 0, 32'h0000_00F0);
    chk_reg("R3 enable set", I_ENS, 0, 32'h0000_00F0);
    wr(I_ENS, 0, 32'h0000_0001);
    chk_reg("R3 zeros keep enables", I_ENS, 0, 32'h0000_00F1);
    wr(I_ENC, 0, 32'h0000_0010);
    chk_reg("R3 enable clear", I_ENS, 0, 32'h0000_00E1);
    chk_reg("R2 high bank untouched", I_ENS, 1, 0);
    wr(I_ENS, 1, 32'h8000_0001);
    chk_reg("R2 high bank enable", I_ENS, 1, 32'h8000_0001);
    chk_reg("R2 low bank untouched", I_ENS, 0, 32'h0000_00E1);
    wr(I_ENC, 0, 32'hFFFF_FFFF);
    wr(I_ENC, 1, 32'hFFFF_FFFF);
    chk_reg("R3 all cleared", I_ENS, 1, 0);
  endtask

  task automatic t_level_route;
    wr(I_ENS, 0, 32'h8);
    @(negedge clk);
    src[3] = 1'b1;
    chk("R11 irq not before edge", 32'(irq_o), 0);
    @(negedge clk);
    chk("R11 irq one edge later", 32'(irq_o), 1);
    chk_reg("R6 raw follows level", I_RAW, 0, 32'h8);
    chk_reg("R10 normal status", I_IRQ, 0, 32'h8);
    chk_reg("R10 fast status empty", I_FIQ, 0, 0);
    wr(I_SEL, 0, 32'h8);
    idle(2);
    chk("R5 routed to fiq", 32'(fiq_o), 1);
    chk("R5 irq dropped", 32'(irq_o), 0);
    chk_reg("R10 fast status", I_FIQ, 0, 32'h8);
    wr(I_SEL, 0, 0);
    wr(I_ENC, 0, 32'h8);
    src[40] = 1'b1;
    wr(I_ENS, 1, 32'h100);
    wr(I_SEL, 1, 32'h100);
    idle(2);
    chk("R5 high bank fiq", 32'(fiq_o), 1);
    chk_reg("R2 high fast status", I_FIQ, 1, 32'h100);
    chk_reg("R2 high normal status", I_IRQ, 1, 0);
    wr(I_SEL, 1, 0);
    wr(I_ENC, 1, 32'h100);
    src[40] = 1'b0;
  endtask

  task automatic t_mask;
    idle(2);
    chk("R12 disabled no irq", 32'(irq_o), 0);
    chk_reg("R12 raw still shows", I_RAW, 0, 32'h8);
    chk_reg("R12 status masked", I_IRQ, 0, 0);
    src[3] = 1'b0;
    chk_reg("R6 level not held", I_RAW, 0, 0);
  endtask

  task automatic t_soft;
    wr(I_TGS, 1, 32'h4);
    chk_reg("R4 trigger mask", I_TGS, 1, 32'h4);
    chk_reg("R4 trigger raw", I_RAW, 1, 32'h4);
    chk("R12 soft masked", 32'(irq_o), 0);
    wr(I_ENS, 1, 32'h4);
    idle(2);
    chk("R4 soft irq", 32'(irq_o), 1);
    chk_reg("R4 soft status", I_IRQ, 1, 32'h4);
    wr(I_TGC, 1, 32'h4);
    idle(2);
    chk("R4 trigger cleared irq", 32'(irq_o), 0);
    chk_reg("R4 trigger mask cleared", I_TGS, 1, 0);
    wr(I_ENC, 1, 32'h4);
  endtask

  task automatic t_edge_rise;
    wr(I_SNS, 0, 32'hFFFF_FF7F);
    wr(I_ENS, 0, 32'h80);
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk); src[7] = 1'b0;
    idle(2);
    chk_reg("R7 rising latched", I_EST, 0, 32'h80);
    chk("R9 latch holds irq", 32'(irq_o), 1);
    wr(I_ECL, 0, 32'h80);
    chk_reg("R9 edge cleared", I_EST, 0, 0);
    idle(1);
    chk("R9 irq after clear", 32'(irq_o), 0);
    src[7] = 1'b1;
    idle(2);
    wr(I_ECL, 0, 32'h80);
    src[7] = 1'b0;
    idle(2);
    chk_reg("R7 falling ignored in rise mode", I_EST, 0, 0);
    wr(I_ENC, 0, 32'h80);
  endtask

  task automatic t_edge_fall;
    wr(I_SNS, 0, 32'hFFFF_FE7F);
    wr(I_EVT, 0, 32'hFFFF_FEFF);
    src[8] = 1'b1;
    idle(2);
    chk_reg("R7 rise ignored in fall mode", I_EST, 0, 0);
    src[8] = 1'b0;
    idle(2);
    chk_reg("R7 falling latched", I_EST, 0, 32'h100);
    wr(I_ECL, 0, 32'h100);
    chk_reg("R9 fall latch cleared", I_EST, 0, 0);
  endtask

  task automatic t_dual;
    wr(I_SNS, 0, 32'hFFFF_FC7F);
    wr(I_DUL, 0, 32'h200);
    src[9] = 1'b1;
    idle(2);
    chk_reg("R8 dual rise", I_EST, 0, 32'h200);
    wr(I_ECL, 0, 32'h200);
    src[9] = 1'b0;
    idle(2);
    chk_reg("R8 dual fall", I_EST, 0, 32'h200);
    wr(I_ECL, 0, 32'h200);
  endtask

  task automatic t_edge_hi;
    wr(I_SNS, 1, 32'hFFFF_FFFE);
    src[32] = 1'b1;
    idle(2);
    chk_reg("R2 high edge latch", I_EST, 1, 32'h1);
    chk_reg("R2 low latch clean", I_EST, 0, 0);
    wr(I_ECL, 1, 32'h1);
    src[32] = 1'b0;
  endtask

  task automatic t_clr_level;
    wr(I_ENS, 0, 32'h8);
    src[3] = 1'b1;
    idle(2);
    wr(I_ECL, 0, 32'h8);
    idle(1);
    chk("R9 clear on level no effect", 32'(irq_o), 1);
    chk_reg("R9 level raw kept", I_RAW, 0, 32'h8);
    chk_reg("R9 level latch zero", I_EST, 0, 0);
    src[3] = 1'b0;
    idle(2);
    chk("R6 level drop clears irq", 32'(irq_o), 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_enable();
        t_level_route();
        t_mask();
        t_soft();
        t_edge_rise();
        t_edge_fall();
        t_dual();
        t_edge_hi();
        t_clr_level();
      end
      begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule